// File: doc/BRIEF.md
# Interrupt Controller Initialization and Mask Port

This block is the programming front end for one unit of a cascaded pair of interrupt controllers. It sits on a byte-wide I/O bus with two addresses. The command address (bus address bit 0 = 0) starts configuration. The data address (bus address bit 0 = 1) carries the remaining configuration words and, once configuration is complete, the interrupt mask. A strap input tells the unit whether it is the master or the slave of the pair.

Configuration runs through four words in a fixed order. The first word goes to the command address. The second, third and fourth words go to the data address, one after another. From these words the block keeps the settings that the controller core needs:

- trigger style
- vector spacing
- the upper bits of the vector base
- special fully nested mode
- automatic end-of-interrupt

When any word breaks a fixed-bit rule, the block raises a sticky violation flag. The written value is still kept. The block drives the eight-bit mask and one derived vector for each input. Priority resolution, acknowledge cycles and in-service tracking belong to the core.

Top module: `intcProgPort`

## Requirements
- R1: After reset the unit is unconfigured (`initDone`=0), the mask reads FFh, `protoErr`=0, and `levelTrig`, `vecSpacing4`, `specialNested` and `autoEoi` are all 0.
- R2: A write to the command address restarts configuration at any point, clears `initDone`, and sets the mask to 00h. Bit 3 of that word drives `levelTrig` (1 = level, 0 = edge). Bit 2 drives `vecSpacing4` (1 = 4-byte, 0 = 8-byte).
- R3: The first data write after the command word sets `vecBase` to its bits 7:3. Vector output n (byte n of `vecOfInput`) equals {`vecBase`, n[2:0]}.
- R4: The second data write after the command word is the cascade identity. It must be 04h when `isSlave`=0 and 02h when `isSlave`=1. Any other value sets `protoErr`.
- R5: The third data write after the command word sets `specialNested` from bit 4 and `autoEoi` from bit 1. It also sets `initDone`.
- R6: Once `initDone`=1, a data write loads the mask, and a data read returns the mask. Mask bit n = 1 masks input n.
- R7: While configuration is in progress, data writes leave the mask unchanged. A data read returns 00h whenever `initDone`=0. A command-address read always returns 00h.
- R8: `protoErr` is set by any of these violations. The values written are still recorded.
  - command word: bits 7:5 ≠ 0, bit 4 ≠ 1, bit 1 ≠ 0, or bit 0 ≠ 1
  - vector word: bits 2:0 ≠ 0
  - mode word: bits 7:5 ≠ 0, bits 3:2 ≠ 0, or bit 0 ≠ 1
  
  The flag holds until the next command write. That write clears it, unless the new command word is itself in violation.
- R9: Data writes made after reset and before any command write have no effect on the mask.
- R10: Every write takes effect on the outputs from the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| isSlave | input | 1 | Strap: 1 = slave unit, 0 = master unit |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read strobe |
| busAddr | input | 1 | 0 = command address, 1 = data address |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data (combinational) |
| initDone | output | 1 | Configuration sequence complete |
| protoErr | output | 1 | Sticky fixed-bit violation flag |
| levelTrig | output | 1 | Level-triggered inputs selected |
| vecSpacing4 | output | 1 | 4-byte vector spacing selected |
| vecBase | output | 5 | Upper bits of the vector base |
| specialNested | output | 1 | Special fully nested mode |
| autoEoi | output | 1 | Automatic end-of-interrupt |
| irqMask | output | 8 | Interrupt mask, bit n masks input n |
| vecOfInput | output | 64 | Derived vector per input, byte n for input n |

## Verification
The hardest states to reach are a restart in the middle of a sequence and a violation flag that stays set across later good words. Reaching them takes exact write orders on the data address that the mask path would otherwise absorb. The stimulus writes a bad vector word and then a wrong identity for the current strap. It then issues a fresh command word partway through, so the clear, the re-set and the mask reset are all seen at the ports. Data writes before any command and during the sequence are each followed by a mask readback, which shows they were dropped.

// File: rtl/intcProgPkg.sv
package intcProgPkg;
  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_WORD2,
    SEQ_WORD3,
    SEQ_WORD4,
    SEQ_READY
  } seqState_t;

  typedef struct packed {
    logic ldWord1;
    logic ldWord2;
    logic ldWord4;
    logic ldMask;
    logic setErr;
  } strobes_t;
endpackage

// File: rtl/intcProgCtrl.sv
module intcProgCtrl
  import intcProgPkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MASTER_ID = 4,
  parameter int SLAVE_ID  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              isSlave,
  input  logic              busWrEn,
  input  logic              busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output strobes_t          strb,
  output logic              initDone
);
  // fixed-bit rules: (data & care) must equal want
  localparam logic [DATA_W-1:0] W1_CARE = DATA_W'(8'hF3);
  localparam logic [DATA_W-1:0] W1_WANT = DATA_W'(8'h11);
  localparam logic [DATA_W-1:0] W2_CARE = DATA_W'(8'h07);
  localparam logic [DATA_W-1:0] W4_CARE = DATA_W'(8'hED);
  localparam logic [DATA_W-1:0] W4_WANT = DATA_W'(8'h01);

  seqState_t stateQ, stateD;
  logic wrCmd, wrData, badWord;
  logic [DATA_W-1:0] idWant;

  assign wrCmd  = busWrEn && !busAddr;
  assign wrData = busWrEn && busAddr;
  assign idWant = isSlave ? DATA_W'(SLAVE_ID) : DATA_W'(MASTER_ID);

  always_comb begin
    badWord = 1'b0;
    if (wrCmd) begin
      badWord = (busWrData & W1_CARE) != W1_WANT;
    end else if (wrData) begin
      case (stateQ)
        SEQ_WORD2: badWord = (busWrData & W2_CARE) != '0;
        SEQ_WORD3: badWord = busWrData != idWant;
        SEQ_WORD4: badWord = (busWrData & W4_CARE) != W4_WANT;
        default:   badWord = 1'b0;
      endcase
    end
  end

  always_comb begin
    stateD = stateQ;
    if (wrCmd) begin
      stateD = SEQ_WORD2;
    end else if (wrData) begin
      case (stateQ)
        SEQ_WORD2: stateD = SEQ_WORD3;
        SEQ_WORD3: stateD = SEQ_WORD4;
        SEQ_WORD4: stateD = SEQ_READY;
        default:   stateD = stateQ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= SEQ_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    strb.ldWord1 = wrCmd;
    strb.ldWord2 = wrData && (stateQ == SEQ_WORD2);
    strb.ldWord4 = wrData && (stateQ == SEQ_WORD4);
    strb.ldMask  = wrData && (stateQ == SEQ_READY);
    strb.setErr  = badWord;
  end

  assign initDone = (stateQ == SEQ_READY);

  // R2: a command write always restarts at the second word
  a_r2_cmd_restarts: assert property (@(posedge clk) disable iff (!rstN)
    wrCmd |=> (stateQ == SEQ_WORD2));

  // R5: the mode word completes configuration
  a_r5_ready_after_mode: assert property (@(posedge clk) disable iff (!rstN)
    (wrData && stateQ == SEQ_WORD4) |=> initDone);

  // R9: data writes while idle leave the sequencer idle
  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == SEQ_IDLE && !wrCmd) |=> (stateQ == SEQ_IDLE));
endmodule

// File: rtl/intcProgRegs.sv
module intcProgRegs
  import intcProgPkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int NUM_IRQ = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobes_t                  strb,
  input  logic                      initDone,
  input  logic                      busRdEn,
  input  logic                      busAddr,
  input  logic [DATA_W-1:0]         busWrData,
  output logic [DATA_W-1:0]         busRdData,
  output logic [NUM_IRQ-1:0]        irqMask,
  output logic                      protoErr,
  output logic                      levelTrig,
  output logic                      vecSpacing4,
  output logic [DATA_W-$clog2(NUM_IRQ)-1:0] vecBase,
  output logic                      specialNested,
  output logic                      autoEoi,
  output logic [NUM_IRQ*DATA_W-1:0] vecOfInput
);
  localparam int IDX_W      = $clog2(NUM_IRQ);
  localparam int BASE_W     = DATA_W - IDX_W;
  localparam int BIT_LEVEL  = 3;
  localparam int BIT_SPACE4 = 2;
  localparam int BIT_SFNM   = 4;
  localparam int BIT_AEOI   = 1;

  logic [NUM_IRQ-1:0] maskQ;
  logic [BASE_W-1:0]  baseQ;
  logic levelQ, space4Q, nestQ, aeoiQ, errQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ   <= '1;
      baseQ   <= '0;
      levelQ  <= 1'b0;
      space4Q <= 1'b0;
      nestQ   <= 1'b0;
      aeoiQ   <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      if (strb.ldWord1) begin
        levelQ  <= busWrData[BIT_LEVEL];
        space4Q <= busWrData[BIT_SPACE4];
        maskQ   <= '0;
      end else if (strb.ldMask) begin
        maskQ <= busWrData[NUM_IRQ-1:0];
      end
      if (strb.ldWord2) baseQ <= busWrData[DATA_W-1:IDX_W];
      if (strb.ldWord4) begin
        nestQ <= busWrData[BIT_SFNM];
        aeoiQ <= busWrData[BIT_AEOI];
      end
      if (strb.ldWord1) errQ <= strb.setErr;
      else if (strb.setErr) errQ <= 1'b1;
    end
  end

  always_comb begin
    busRdData = '0;
    if (busRdEn && busAddr && initDone) busRdData = DATA_W'(maskQ);
  end

  for (genvar g = 0; g < NUM_IRQ; g++) begin : genVec
    assign vecOfInput[g*DATA_W +: DATA_W] = {baseQ, IDX_W'(g)};
  end

  assign irqMask       = maskQ;
  assign protoErr      = errQ;
  assign levelTrig     = levelQ;
  assign vecSpacing4   = space4Q;
  assign vecBase       = baseQ;
  assign specialNested = nestQ;
  assign autoEoi       = aeoiQ;

  // R6: mask loads the written byte once configured
  a_r6_mask_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.ldMask |=> (maskQ == $past(busWrData[NUM_IRQ-1:0])));

  // R7: mask untouched while unconfigured except by a restart
  a_r7_mask_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!initDone && !strb.ldWord1) |=> $stable(maskQ));

  // R8: violation flag only clears on a command write
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (errQ && !strb.ldWord1) |=> errQ);

  // R3: vector word captured
  a_r3_base_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.ldWord2 |=> (baseQ == $past(busWrData[DATA_W-1:IDX_W])));
endmodule

// File: rtl/intcProgPort.sv
module intcProgPort
  import intcProgPkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_IRQ   = 8,
  parameter int MASTER_ID = 4,
  parameter int SLAVE_ID  = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      isSlave,
  input  logic                      busWrEn,
  input  logic                      busRdEn,
  input  logic                      busAddr,
  input  logic [DATA_W-1:0]         busWrData,
  output logic [DATA_W-1:0]         busRdData,
  output logic                      initDone,
  output logic                      protoErr,
  output logic                      levelTrig,
  output logic                      vecSpacing4,
  output logic [DATA_W-$clog2(NUM_IRQ)-1:0] vecBase,
  output logic                      specialNested,
  output logic                      autoEoi,
  output logic [NUM_IRQ-1:0]        irqMask,
  output logic [NUM_IRQ*DATA_W-1:0] vecOfInput
);
  strobes_t strb;

  intcProgCtrl #(.DATA_W(DATA_W), .MASTER_ID(MASTER_ID), .SLAVE_ID(SLAVE_ID)) ctrl (
    .clk(clk), .rstN(rstN), .isSlave(isSlave), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .strb(strb), .initDone(initDone)
  );

  intcProgRegs #(.DATA_W(DATA_W), .NUM_IRQ(NUM_IRQ)) regs (
    .clk(clk), .rstN(rstN), .strb(strb), .initDone(initDone),
    .busRdEn(busRdEn), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .irqMask(irqMask), .protoErr(protoErr),
    .levelTrig(levelTrig), .vecSpacing4(vecSpacing4), .vecBase(vecBase),
    .specialNested(specialNested), .autoEoi(autoEoi), .vecOfInput(vecOfInput)
  );
endmodule

// File: tb/intcProgPort_test.sv
module intcProgPort_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic isSlave = 1'b0, busWrEn = 1'b0, busRdEn = 1'b0, busAddr = 1'b0;
  logic [7:0] busWrData = '0, busRdData, irqMask;
  logic initDone, protoErr, levelTrig, vecSpacing4, specialNested, autoEoi;
  logic [4:0] vecBase;
  logic [63:0] vecOfInput;

  always #10 clk = ~clk;  // 50 MHz

  intcProgPort uut (
    .clk(clk), .rstN(rstN), .isSlave(isSlave), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .initDone(initDone), .protoErr(protoErr),
    .levelTrig(levelTrig), .vecSpacing4(vecSpacing4), .vecBase(vecBase),
    .specialNested(specialNested), .autoEoi(autoEoi), .irqMask(irqMask),
    .vecOfInput(vecOfInput)
  );

  typedef struct {
    int          sel;
    string       req;
    logic [63:0] exp;
  } expItem_t;

  expItem_t sbQ[$];
  int total = 0, fails = 0;
  bit finished = 0;

  function automatic logic [63:0] observe(int sel);
    case (sel)
      0: return 64'(irqMask);
      1: return 64'(initDone);
      2: return 64'(protoErr);
      3: return 64'(levelTrig);
      4: return 64'(vecSpacing4);
      5: return 64'(vecBase);
      6: return 64'(specialNested);
      7: return 64'(autoEoi);
      8: return 64'(busRdData);
      default: return vecOfInput;
    endcase
  endfunction

  // monitor: compare queued expectations away from the active edge
  always @(negedge clk) begin
    while (sbQ.size() > 0) begin
      expItem_t it;
      logic [63:0] act;
      it = sbQ.pop_front();
      act = observe(it.sel);
      total++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s sel=%0d actual=%0h expected=%0h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic expect_(int sel, string req, logic [63:0] exp);
    expItem_t it;
    it.sel = sel; it.req = req; it.exp = exp;
    sbQ.push_back(it);
  endtask

  task automatic busWrite(logic addr, logic [7:0] d);
    @(posedge clk); #1;
    busWrEn = 1'b1; busAddr = addr; busWrData = d;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic busReadExp(logic addr, logic [7:0] exp, string req);
    @(posedge clk); #1;
    busRdEn = 1'b1; busAddr = addr;
    expect_(8, req, 64'(exp));
    @(negedge clk); #1;
    busRdEn = 1'b0;
  endtask

  function automatic logic [63:0] vecModel(logic [4:0] base);
    logic [63:0] v;
    for (int n = 0; n < 8; n++) v[n*8 +: 8] = {base, 3'(n)};
    return v;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    expect_(0, "R1", 64'hFF); expect_(1, "R1", 0); expect_(2, "R1", 0);
    expect_(3, "R1", 0); expect_(4, "R1", 0); expect_(6, "R1", 0); expect_(7, "R1", 0);
    busReadExp(1'b1, 8'h00, "R7");
    // R9 data write while idle
    busWrite(1'b1, 8'h5A);
    expect_(0, "R9", 64'hFF); expect_(1, "R9", 0);
    // master sequence, R2 and R10 effect at the capturing edge
    busWrite(1'b0, 8'h19);
    expect_(3, "R2", 1); expect_(4, "R2", 0); expect_(0, "R2", 0); expect_(2, "R8", 0);
    busWrite(1'b1, 8'h40);
    expect_(5, "R3", 64'h08); expect_(9, "R3", vecModel(5'h08)); expect_(0, "R7", 0);
    busReadExp(1'b1, 8'h00, "R7");
    busWrite(1'b1, 8'h04);
    expect_(2, "R4", 0); expect_(0, "R7", 0); expect_(1, "R5", 0);
    busWrite(1'b1, 8'h13);
    expect_(6, "R5", 1); expect_(7, "R5", 1); expect_(1, "R5", 1); expect_(2, "R8", 0);
    busWrite(1'b1, 8'hA5);
    expect_(0, "R6", 64'hA5);
    busReadExp(1'b1, 8'hA5, "R6");
    busReadExp(1'b0, 8'h00, "R7");
    // slave unit: bad vector word, wrong identity, then restart
    isSlave = 1'b1;
    busWrite(1'b0, 8'h15);
    expect_(3, "R2", 0); expect_(4, "R2", 1); expect_(0, "R2", 0); expect_(1, "R2", 0);
    busWrite(1'b1, 8'h73);
    expect_(2, "R8", 1); expect_(5, "R8", 64'h0E); expect_(9, "R3", vecModel(5'h0E));
    busWrite(1'b1, 8'h04);
    expect_(2, "R4", 1);
    busWrite(1'b0, 8'h11);
    expect_(2, "R8", 0); expect_(1, "R2", 0);
    busWrite(1'b1, 8'h20);
    busWrite(1'b1, 8'h02);
    expect_(2, "R4", 0);
    busWrite(1'b1, 8'h01);
    expect_(1, "R5", 1); expect_(6, "R5", 0); expect_(7, "R5", 0); expect_(5, "R3", 64'h04);
    busWrite(1'b1, 8'h3C);
    busReadExp(1'b1, 8'h3C, "R6");
    // bad command word
    busWrite(1'b0, 8'h10);
    expect_(2, "R8", 1); expect_(0, "R2", 0);
    // master identity offered to slave
    busWrite(1'b0, 8'h11);
    busWrite(1'b1, 8'h00);
    expect_(2, "R8", 0);
    busWrite(1'b1, 8'h04);
    expect_(2, "R4", 1);
    // bad mode word still recorded and completes
    busWrite(1'b0, 8'h11);
    busWrite(1'b1, 8'h00);
    busWrite(1'b1, 8'h02);
    busWrite(1'b1, 8'h93);
    expect_(2, "R8", 1); expect_(1, "R5", 1); expect_(6, "R8", 1); expect_(7, "R8", 1);
    repeat (3) @(posedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule